// File: doc/BRIEF.md
# Inverse Square Root Operand Prefixup

This block screens one single-precision floating-point operand before an iterative reciprocal-square-root engine runs. It resolves every special input on the spot: NaN, negative values, positive infinity and zeros. For those inputs it gives a final result and tells the engine to skip its iterations. For ordinary positive inputs it sets the result to zero and asserts a continue flag. When the exponent is small, it also multiplies the operand by 2^64, so the later refinement keeps full precision. It then tags that operand with an 8-bit adjust code, which the later exponent correction uses to undo the scaling.

The screening logic is purely combinational. The top level registers it behind a valid strobe. Each operand presented with `in_valid` high gives one result one clock later, with `out_valid` high. The invalid-operation flag is a single-cycle pulse aligned with that `out_valid` cycle. The data outputs hold their last value while no new operand arrives.

Top module: `isqrt_prefix`

## Requirements
- R1: An input whose exponent field is all ones and whose fraction is nonzero (a NaN, of either sign) yields 0xFFFFFFFF on both the operand and result outputs, with continue 0 and adjust 0.
- R2: For a NaN input, the invalid flag is raised only when fraction bit 22 (the quiet bit) is 0; a quiet NaN raises nothing.
- R3: A non-NaN input with sign bit 31 set and a nonzero magnitude (this includes negative infinity and negative subnormals) yields 0xFFFFFFFF on both outputs and raises invalid.
- R4: Positive infinity (0x7F800000) yields 0x7F800000 on both outputs, without invalid.
- R5: A zero of either sign passes the operand through unchanged, gives result 0x3F800000 (1.0), and does not raise invalid.
- R6: A positive normal input whose 8-bit exponent field (bits 30:23) is at most 24 leaves with its exponent field increased by 64, its fraction unchanged, and adjust 0xE0.
- R7: A positive subnormal input is renormalized and multiplied exactly by 2^64, giving a normal operand with adjust 0xE0 (for example 0x00000001 becomes 0x15000000).
- R8: A positive finite input whose exponent field is greater than 24 passes through unchanged with adjust 0x00.
- R9: On the normal path (R6 to R8), the result is 0 and continue is 1; every special case (R1 to R5) gives continue 0 and adjust 0.
- R10: Outputs update one clock after an edge that samples `in_valid` high, with `out_valid` high for that one cycle. `out_invalid` is high only in such a cycle. Operand, result, adjust and continue hold their values while `in_valid` is low.
- R11: While reset is asserted and after its release, all outputs are zero until the first valid operand arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| in_op | input | 32 | Single-precision operand |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_op | output | 32 | Screened and possibly rescaled operand |
| out_res | output | 32 | Direct result for special cases, else 0 |
| out_adj | output | 8 | Adjust code (0xE0 when scaled) |
| out_cont | output | 1 | Iterative computation must run |
| out_invalid | output | 1 | Invalid-operation pulse |

## Verification
The bench targets the priority edges among the special cases:
- A negative quiet NaN must follow the NaN rule, which raises no invalid flag. A design that tests the sign first would flag it as invalid.
- Negative zero must behave as a zero. A plain sign test would turn it into NaN.
- Negative infinity must be treated as negative, not as infinity.

On the scaling side, the bench applies exponent fields of exactly 24 and 25 to catch an off-by-one in the compare. It also applies subnormals with the leading one at the lowest and highest bit positions; a design that only added 64 to the exponent field would return a wrong, unnormalized value for these. Finally, the bench checks that the invalid pulse drops while the data outputs hold in the cycle after a valid operand.

// File: rtl/isqrt_pre_pkg.sv
package isqrt_pre_pkg;

  localparam int EXP_W = 8;
  localparam int MAN_W = 23;
  localparam int FP_W  = 1 + EXP_W + MAN_W;

  typedef struct packed {
    logic             sign;
    logic [EXP_W-1:0] expo;
    logic [MAN_W-1:0] frac;
  } fp_word_t;

  typedef struct packed {
    logic is_nan;
    logic is_inf;
    logic is_zero;
    logic is_neg;
    logic is_small;
    logic is_quiet;
  } fp_class_t;

  typedef enum logic [2:0] {
    SEL_NAN,
    SEL_NEG,
    SEL_INF,
    SEL_ZERO,
    SEL_NORM
  } sel_path_e;

  localparam logic [FP_W-1:0] FP_ALL_ONES = '1;
  localparam logic [FP_W-1:0] FP_POS_INF  = {1'b0, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
  localparam logic [FP_W-1:0] FP_UNITY    = {2'b00, {(EXP_W-1){1'b1}}, {MAN_W{1'b0}}};

endpackage

// File: rtl/isqrt_pre_classify.sv
module isqrt_pre_classify
  import isqrt_pre_pkg::*;
#(
  parameter int SMALL_EXP_MAX = 24
) (
  input  fp_word_t  op_i,
  output fp_class_t cls_o
);

  localparam logic [EXP_W-1:0] SMALL_LIM = EXP_W'(SMALL_EXP_MAX);

  logic exp_max;
  logic exp_min;
  logic frac_nz;

  always_comb begin
    exp_max = &op_i.expo;
    exp_min = ~|op_i.expo;
    frac_nz = |op_i.frac;

    cls_o.is_nan   = exp_max & frac_nz;
    cls_o.is_inf   = exp_max & ~frac_nz;
    cls_o.is_zero  = exp_min & ~frac_nz;
    cls_o.is_neg   = op_i.sign;
    cls_o.is_small = (op_i.expo <= SMALL_LIM);
    cls_o.is_quiet = op_i.frac[MAN_W-1];
  end

endmodule

// File: rtl/isqrt_pre_upscale.sv
module isqrt_pre_upscale
  import isqrt_pre_pkg::*;
#(
  parameter int SCALE_POW = 64
) (
  input  fp_word_t op_i,
  output fp_word_t op_o
);

  localparam int POS_W    = $clog2(MAN_W + 1);
  localparam int DEN_BASE = SCALE_POW + 1 - MAN_W;
  localparam logic [POS_W-1:0] TOP_POS = POS_W'(MAN_W);

  logic [MAN_W-1:0] lead_hot;
  logic [POS_W-1:0] lead_pos;
  logic [POS_W-1:0] shift_amt;
  logic             subnormal;

  // One-hot of the highest set fraction bit.
  genvar gi;
  generate
    for (gi = 0; gi < MAN_W; gi++) begin : g_lead
      if (gi == MAN_W - 1) begin : g_top
        assign lead_hot[gi] = op_i.frac[gi];
      end else begin : g_rest
        assign lead_hot[gi] = op_i.frac[gi] & ~|op_i.frac[MAN_W-1:gi+1];
      end
    end
  endgenerate

  always_comb begin
    lead_pos = '0;
    for (int i = 0; i < MAN_W; i++) begin
      if (lead_hot[i]) lead_pos = POS_W'(i);
    end
  end

  always_comb begin
    subnormal = ~|op_i.expo;
    shift_amt = TOP_POS - lead_pos;
    op_o.sign = op_i.sign;
    if (subnormal) begin
      // Leading one moves to the hidden position and drops out of the field.
      op_o.expo = EXP_W'(DEN_BASE) + EXP_W'(lead_pos);
      op_o.frac = op_i.frac << shift_amt;
    end else begin
      op_o.expo = op_i.expo + EXP_W'(SCALE_POW);
      op_o.frac = op_i.frac;
    end
  end

endmodule

// File: rtl/isqrt_pre_core.sv
module isqrt_pre_core
  import isqrt_pre_pkg::*;
#(
  parameter int         SMALL_EXP_MAX = 24,
  parameter int         SCALE_POW     = 64,
  parameter logic [7:0] ADJ_SMALL     = 8'hE0
) (
  input  logic [FP_W-1:0] op_i,
  output logic [FP_W-1:0] op_o,
  output logic [FP_W-1:0] res_o,
  output logic [7:0]      adj_o,
  output logic            cont_o,
  output logic            invalid_o
);

  fp_word_t  in_w;
  fp_word_t  scaled_w;
  fp_class_t cls;
  sel_path_e path;

  assign in_w = fp_word_t'(op_i);

  isqrt_pre_classify #(
    .SMALL_EXP_MAX(SMALL_EXP_MAX)
  ) u_classify (
    .op_i (in_w),
    .cls_o(cls)
  );

  isqrt_pre_upscale #(
    .SCALE_POW(SCALE_POW)
  ) u_upscale (
    .op_i(in_w),
    .op_o(scaled_w)
  );

  // Fixed priority: NaN, then negative nonzero, then infinity, then zero.
  always_comb begin
    if (cls.is_nan)                     path = SEL_NAN;
    else if (cls.is_neg & ~cls.is_zero) path = SEL_NEG;
    else if (cls.is_inf)                path = SEL_INF;
    else if (cls.is_zero)               path = SEL_ZERO;
    else                                path = SEL_NORM;
  end

  always_comb begin
    op_o      = op_i;
    res_o     = '0;
    adj_o     = '0;
    cont_o    = 1'b0;
    invalid_o = 1'b0;
    case (path)
      SEL_NAN: begin
        op_o      = FP_ALL_ONES;
        res_o     = FP_ALL_ONES;
        invalid_o = ~cls.is_quiet;
      end
      SEL_NEG: begin
        op_o      = FP_ALL_ONES;
        res_o     = FP_ALL_ONES;
        invalid_o = 1'b1;
      end
      SEL_INF: begin
        op_o  = FP_POS_INF;
        res_o = FP_POS_INF;
      end
      SEL_ZERO: begin
        res_o = FP_UNITY;
      end
      default: begin
        cont_o = 1'b1;
        if (cls.is_small) begin
          op_o  = FP_W'(scaled_w);
          adj_o = ADJ_SMALL;
        end
      end
    endcase
  end

endmodule

// File: rtl/isqrt_prefix.sv
module isqrt_prefix
  import isqrt_pre_pkg::*;
#(
  parameter int         SMALL_EXP_MAX = 24,
  parameter int         SCALE_POW     = 64,
  parameter logic [7:0] ADJ_SMALL     = 8'hE0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_op,
  output logic        out_valid,
  output logic [31:0] out_op,
  output logic [31:0] out_res,
  output logic [7:0]  out_adj,
  output logic        out_cont,
  output logic        out_invalid
);

  logic [FP_W-1:0] core_op, core_res;
  logic [7:0]      core_adj;
  logic            core_cont, core_inv;

  logic [FP_W-1:0] op_d, op_q, res_d, res_q;
  logic [7:0]      adj_d, adj_q;
  logic            cont_d, cont_q, vld_d, vld_q, inv_d, inv_q;

  isqrt_pre_core #(
    .SMALL_EXP_MAX(SMALL_EXP_MAX),
    .SCALE_POW    (SCALE_POW),
    .ADJ_SMALL    (ADJ_SMALL)
  ) u_core (
    .op_i     (in_op),
    .op_o     (core_op),
    .res_o    (core_res),
    .adj_o    (core_adj),
    .cont_o   (core_cont),
    .invalid_o(core_inv)
  );

  always_comb begin
    vld_d  = in_valid;
    inv_d  = in_valid & core_inv;
    op_d   = in_valid ? core_op   : op_q;
    res_d  = in_valid ? core_res  : res_q;
    adj_d  = in_valid ? core_adj  : adj_q;
    cont_d = in_valid ? core_cont : cont_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      inv_q  <= 1'b0;
      op_q   <= '0;
      res_q  <= '0;
      adj_q  <= '0;
      cont_q <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      inv_q  <= inv_d;
      op_q   <= op_d;
      res_q  <= res_d;
      adj_q  <= adj_d;
      cont_q <= cont_d;
    end
  end

  assign out_valid   = vld_q;
  assign out_invalid = inv_q;
  assign out_op      = op_q;
  assign out_res     = res_q;
  assign out_adj     = adj_q;
  assign out_cont    = cont_q;

  // R10: invalid is a pulse tied to a fresh result
  a_r10_invalid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_invalid |-> out_valid);

  // R10: data holds when no operand was sampled
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> ($stable(out_op) && $stable(out_res) && $stable(out_adj)));

  // R9: continuing path returns a zero result
  a_r9_cont_zero_res: assert property (@(posedge clk) disable iff (!rst_n)
    out_cont |-> (out_res == '0 && !out_invalid));

  // R6: a nonzero adjust code only on the continuing path
  a_r6_adj_needs_cont: assert property (@(posedge clk) disable iff (!rst_n)
    (out_adj != '0) |-> (out_cont && out_adj == ADJ_SMALL));

  // R5: zero operand gives unity and passes through
  a_r5_zero_unity: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_op[30:0]) == '0) |->
      (out_res == FP_UNITY && out_op == $past(in_op) && !out_invalid));

  // R1: NaN operand gives the all-ones pattern
  a_r1_nan_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (&$past(in_op[30:23])) && (|$past(in_op[22:0]))) |->
      (out_op == FP_ALL_ONES && out_res == FP_ALL_ONES && !out_cont));

endmodule

// File: tb/isqrt_prefix_tb.sv
`timescale 1ns/1ps
module isqrt_prefix_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_op = '0;
  logic        out_valid, out_cont, out_invalid;
  logic [31:0] out_op, out_res;
  logic [7:0]  out_adj;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  isqrt_prefix u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .out_valid(out_valid), .out_op(out_op), .out_res(out_res),
    .out_adj(out_adj), .out_cont(out_cont), .out_invalid(out_invalid)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // Apply one operand and check every output in the cycle it appears.
  task automatic apply(input string tag, input logic [31:0] v,
                       input logic [31:0] e_op, input logic [31:0] e_res,
                       input logic [7:0] e_adj, input logic e_cont, input logic e_inv);
    @(negedge clk);
    in_valid = 1'b1;
    in_op    = v;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " R10 valid"}, {31'd0, out_valid}, 32'd1);
    chk({tag, " op"},      out_op,  e_op);
    chk({tag, " res"},     out_res, e_res);
    chk({tag, " adj"},     {24'd0, out_adj}, {24'd0, e_adj});
    chk({tag, " cont"},    {31'd0, out_cont}, {31'd0, e_cont});
    chk({tag, " invalid"}, {31'd0, out_invalid}, {31'd0, e_inv});
  endtask

  task automatic t_reset();
    chk("R11 valid", {31'd0, out_valid}, 32'd0);
    chk("R11 op",    out_op, 32'd0);
    chk("R11 res",   out_res, 32'd0);
    chk("R11 flags", {22'd0, out_adj, out_cont, out_invalid}, 32'd0);
  endtask

  task automatic t_nan();
    apply("R1 R2 quiet nan",   32'h7FC00000, '1, '1, 8'h00, 1'b0, 1'b0);
    apply("R1 R2 signal nan",  32'h7F800001, '1, '1, 8'h00, 1'b0, 1'b1);
    apply("R1 R2 neg quiet nan", 32'hFFC00001, '1, '1, 8'h00, 1'b0, 1'b0);
    apply("R1 R2 neg signal nan", 32'hFFA00000, '1, '1, 8'h00, 1'b0, 1'b1);
  endtask

  task automatic t_negative();
    apply("R3 minus one",      32'hBF800000, '1, '1, 8'h00, 1'b0, 1'b1);
    apply("R3 minus inf",      32'hFF800000, '1, '1, 8'h00, 1'b0, 1'b1);
    apply("R3 minus subnormal", 32'h80000001, '1, '1, 8'h00, 1'b0, 1'b1);
  endtask

  task automatic t_infinity();
    apply("R4 plus inf", 32'h7F800000, 32'h7F800000, 32'h7F800000, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic t_zero();
    apply("R5 plus zero",  32'h00000000, 32'h00000000, 32'h3F800000, 8'h00, 1'b0, 1'b0);
    apply("R5 minus zero", 32'h80000000, 32'h80000000, 32'h3F800000, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic t_small();
    apply("R6 R9 exp 24", 32'h0C123456, 32'h2C123456, 32'h0, 8'hE0, 1'b1, 1'b0);
    apply("R6 R9 exp 1",  32'h00800000, 32'h20800000, 32'h0, 8'hE0, 1'b1, 1'b0);
  endtask

  task automatic t_subnormal();
    apply("R7 lowest bit",  32'h00000001, 32'h15000000, 32'h0, 8'hE0, 1'b1, 1'b0);
    apply("R7 top bit",     32'h00400000, 32'h20000000, 32'h0, 8'hE0, 1'b1, 1'b0);
    apply("R7 all bits",    32'h007FFFFF, 32'h207FFFFE, 32'h0, 8'hE0, 1'b1, 1'b0);
  endtask

  task automatic t_large();
    apply("R8 R9 exp 25",   32'h0C800000, 32'h0C800000, 32'h0, 8'h00, 1'b1, 1'b0);
    apply("R8 R9 one",      32'h3F800000, 32'h3F800000, 32'h0, 8'h00, 1'b1, 1'b0);
    apply("R8 R9 max norm", 32'h7F7FFFFF, 32'h7F7FFFFF, 32'h0, 8'h00, 1'b1, 1'b0);
  endtask

  task automatic t_hold();
    apply("R10 pre", 32'hFF800000, '1, '1, 8'h00, 1'b0, 1'b1);
    in_op = 32'h3F800000;
    @(negedge clk);
    chk("R10 valid drop",   {31'd0, out_valid}, 32'd0);
    chk("R10 invalid drop", {31'd0, out_invalid}, 32'd0);
    chk("R10 op held",      out_op, 32'hFFFFFFFF);
    chk("R10 res held",     out_res, 32'hFFFFFFFF);
  endtask

  initial begin
    #12;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_nan();
    t_negative();
    t_infinity();
    t_zero();
    t_small();
    t_subnormal();
    t_large();
    t_hold();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule